// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block produces the raster timing for a 320x240 TFT panel: an active-low horizontal sync, an active-low vertical sync and an active-video strobe, together with the current line number and the tick position inside the line. Every horizontal quantity is counted in ticks of the pixel-port clock. It is multiplied by a clocks-per-pixel factor of 1, 2 or 3, chosen by a mode input, so the same generator serves a wide port that moves a whole pixel per tick and narrow ports that move a pixel over two or three ticks.

A line lasts 336 pixel times. Sync is low for the first 2 pixel times of each line. The visible window opens 7 pixel times into the line, plus a fixed per-mode pipeline correction, and stays open for 320 pixel times. A frame has 240 visible lines plus 4 blanking lines. The blanking is split evenly, so two blank lines come before the visible area and two come after it. Vertical sync is low at the start of line 0 for 2 pixel times.

When the enable is dropped, both counters return to zero and every output goes idle. When the enable is raised again, a new frame starts from its first tick. A new mode is taken when the generator starts and at each frame boundary, never in the middle of a frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: During reset, and on any cycle that follows a clock edge at which enable was low, hsync_n and vsync_n are 1, de is 0, and slot_cnt and line_cnt are 0.
- R2: While running, slot_cnt rises by 1 every clock and returns to 0 after reaching LINE_PIX*cpp-1. With the defaults this is 335, 671 or 1007.
- R3: line_cnt advances by 1 each time slot_cnt wraps. After line ACT_H+BLANK_LINES-1 (243 by default) it returns to 0, and it never reaches ACT_H+BLANK_LINES.
- R4: While running, hsync_n is 0 exactly when slot_cnt < HS_PIX*cpp, on every line.
- R5: While running, vsync_n is 0 exactly when line_cnt is 0 and slot_cnt < VS_PIX*cpp.
- R6: de is 1 exactly when line_cnt lies in [BLANK_LINES/2, BLANK_LINES/2+ACT_H) (lines 2 to 241 by default) and slot_cnt lies in [S, S+ACT_W*cpp), where S = START_PIX*cpp + correction.
- R7: mode_sel encoding: 2'b00 selects cpp=1, 2'b01 selects cpp=2, 2'b10 selects cpp=3, and the reserved code 2'b11 behaves as 2'b00.
- R8: The pipeline correction added to S is CORR_1, CORR_2 or CORR_3 clocks (0, 3, 5 by default) for cpp 1, 2, 3. The first de tick of a visible line is therefore at slot S, and the slot before it has de at 0.
- R9: After a clock edge at which enable is high following an idle cycle, the outputs show line 0, slot 0, with hsync_n and vsync_n both 0. The mode used is the one sampled at that edge.
- R10: A change on mode_sel while running has no effect until the edge that wraps line ACT_H+BLANK_LINES-1 to line 0. The new cpp applies from that first tick of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low holds the generator idle |
| mode_sel | input | 2 | Clocks-per-pixel select (see R7) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active-video strobe |
| line_cnt | output | LINE_W | Current line, 0 at the top of the frame |
| slot_cnt | output | SLOT_W | Current tick within the line |

## Verification
The hardest case to reach from the ports is a mode change that lands in the middle of a frame. It must not alter the line length until the frame wraps, and after the wrap the line length, the sync widths and the corrected start of the visible window must all change together. The bench shrinks the geometry through parameters so that a frame is a few hundred ticks. It switches mode_sel partway through a frame and walks through the wrap while it compares every output on every tick against an arithmetic model. It also drops enable in the middle of a line and restarts, which confirms that the restart always begins at line 0 and slot 0.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

   localparam int MODES = 3;
   localparam int TW    = 16;

   typedef logic [TW-1:0] tick_t;

   typedef enum logic [1:0] {
      CPP1 = 2'd0,
      CPP2 = 2'd1,
      CPP3 = 2'd2
   } cpp_idx_e;

   typedef struct packed {
      tick_t line_last;
      tick_t hs_end;
      tick_t vs_end;
      tick_t de_start;
      tick_t de_end;
   } lim_t;

   function automatic cpp_idx_e decode_mode(input logic [1:0] sel);
      cpp_idx_e r;
      case (sel)
         2'b01:   r = CPP2;
         2'b10:   r = CPP3;
         default: r = CPP1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/lcdt_mode_reg.sv
module lcdt_mode_reg
   import lcdt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] mode_sel,
   output cpp_idx_e   idx_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= CPP1;
      else if (load)
         idx_q <= decode_mode(mode_sel);
   end

endmodule

// File: rtl/lcdt_limits.sv
module lcdt_limits
   import lcdt_pkg::*;
#(
   parameter int LINE_PIX  = 336,
   parameter int HS_PIX    = 2,
   parameter int VS_PIX    = 2,
   parameter int START_PIX = 7,
   parameter int ACT_W     = 320,
   parameter int CORR_1    = 0,
   parameter int CORR_2    = 3,
   parameter int CORR_3    = 5
) (
   input  cpp_idx_e idx,
   output lim_t     lim
);

   lim_t tbl [MODES];

   for (genvar m = 0; m < MODES; m++) begin : g_mode
      localparam int CPP   = m + 1;
      localparam int CORR  = (m == 0) ? CORR_1 : ((m == 1) ? CORR_2 : CORR_3);
      localparam int START = START_PIX * CPP + CORR;
      assign tbl[m] = '{
         line_last: tick_t'(LINE_PIX * CPP - 1),
         hs_end:    tick_t'(HS_PIX * CPP),
         vs_end:    tick_t'(VS_PIX * CPP),
         de_start:  tick_t'(START),
         de_end:    tick_t'(START + ACT_W * CPP)
      };
   end

   always_comb begin
      case (idx)
         CPP2:    lim = tbl[1];
         CPP3:    lim = tbl[2];
         default: lim = tbl[0];
      endcase
   end

endmodule

// File: rtl/lcdt_counters.sv
module lcdt_counters
   import lcdt_pkg::*;
#(
   parameter int SLOT_W      = 10,
   parameter int LINE_W      = 8,
   parameter int LINES_TOTAL = 244
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  tick_t             line_last,
   output logic              run_q,
   output logic [SLOT_W-1:0] slot_q,
   output logic [LINE_W-1:0] line_q,
   output logic              load
);

   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_TOTAL - 1);

   logic line_end;
   logic frame_end;

   assign line_end  = (tick_t'(slot_q) == line_last);
   assign frame_end = line_end && (line_q == LAST_LINE);
   assign load      = enable && (!run_q || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         slot_q <= '0;
         line_q <= '0;
      end else if (!enable) begin
         run_q  <= 1'b0;
         slot_q <= '0;
         line_q <= '0;
      end else if (!run_q) begin
         run_q  <= 1'b1;
         slot_q <= '0;
         line_q <= '0;
      end else if (line_end) begin
         slot_q <= '0;
         line_q <= frame_end ? '0 : line_q + 1'b1;
      end else begin
         slot_q <= slot_q + 1'b1;
      end
   end

endmodule

// File: rtl/lcdt_decode.sv
module lcdt_decode
   import lcdt_pkg::*;
#(
   parameter int SLOT_W    = 10,
   parameter int LINE_W    = 8,
   parameter int TOP_BLANK = 2,
   parameter int ACT_H     = 240
) (
   input  logic              run,
   input  logic [SLOT_W-1:0] slot,
   input  logic [LINE_W-1:0] line,
   input  tick_t             hs_end,
   input  tick_t             vs_end,
   input  tick_t             de_start,
   input  tick_t             de_end,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic              de
);

   localparam tick_t FIRST_VIS = tick_t'(TOP_BLANK);
   localparam tick_t END_VIS   = tick_t'(TOP_BLANK + ACT_H);

   tick_t s;
   tick_t l;
   logic  in_lines;
   logic  in_slots;

   always_comb begin
      s        = tick_t'(slot);
      l        = tick_t'(line);
      in_lines = (l >= FIRST_VIS) && (l < END_VIS);
      in_slots = (s >= de_start) && (s < de_end);
      hsync_n  = !(run && (s < hs_end));
      vsync_n  = !(run && (l == '0) && (s < vs_end));
      de       = run && in_lines && in_slots;
   end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
   import lcdt_pkg::*;
#(
   parameter int ACT_W       = 320,
   parameter int ACT_H       = 240,
   parameter int BLANK_LINES = 4,
   parameter int LINE_PIX    = 336,
   parameter int HS_PIX      = 2,
   parameter int VS_PIX      = 2,
   parameter int START_PIX   = 7,
   parameter int CORR_1      = 0,
   parameter int CORR_2      = 3,
   parameter int CORR_3      = 5,
   localparam int LINES_TOTAL = ACT_H + BLANK_LINES,
   localparam int TOP_BLANK   = BLANK_LINES / 2,
   localparam int MAX_TICKS   = LINE_PIX * MODES,
   localparam int SLOT_W      = $clog2(MAX_TICKS),
   localparam int LINE_W      = $clog2(LINES_TOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        mode_sel,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic              de,
   output logic [LINE_W-1:0] line_cnt,
   output logic [SLOT_W-1:0] slot_cnt
);

   // Configuration checks at elaboration
   if (MAX_TICKS > (1 << TW)) begin : g_bad_width
      $error("line period does not fit the timing word");
   end
   if (BLANK_LINES < 2 || ACT_H < 1 || ACT_W < 1) begin : g_bad_frame
      $error("frame geometry out of range");
   end
   if (HS_PIX < 1 || VS_PIX < 1) begin : g_bad_sync
      $error("sync widths must be at least one pixel");
   end
   for (genvar m = 0; m < MODES; m++) begin : g_fit
      localparam int CPP  = m + 1;
      localparam int CORR = (m == 0) ? CORR_1 : ((m == 1) ? CORR_2 : CORR_3);
      if (START_PIX * CPP + CORR + ACT_W * CPP > LINE_PIX * CPP) begin : g_bad_fit
         $error("visible window overruns the line");
      end
   end

   cpp_idx_e          idx_q;
   lim_t              lim;
   logic              run_q;
   logic              load;
   logic [SLOT_W-1:0] slot_q;
   logic [LINE_W-1:0] line_q;

   lcdt_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .mode_sel (mode_sel),
      .idx_q    (idx_q)
   );

   lcdt_limits #(
      .LINE_PIX  (LINE_PIX),
      .HS_PIX    (HS_PIX),
      .VS_PIX    (VS_PIX),
      .START_PIX (START_PIX),
      .ACT_W     (ACT_W),
      .CORR_1    (CORR_1),
      .CORR_2    (CORR_2),
      .CORR_3    (CORR_3)
   ) u_lim (
      .idx (idx_q),
      .lim (lim)
   );

   lcdt_counters #(
      .SLOT_W      (SLOT_W),
      .LINE_W      (LINE_W),
      .LINES_TOTAL (LINES_TOTAL)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .line_last (lim.line_last),
      .run_q     (run_q),
      .slot_q    (slot_q),
      .line_q    (line_q),
      .load      (load)
   );

   lcdt_decode #(
      .SLOT_W    (SLOT_W),
      .LINE_W    (LINE_W),
      .TOP_BLANK (TOP_BLANK),
      .ACT_H     (ACT_H)
   ) u_dec (
      .run      (run_q),
      .slot     (slot_q),
      .line     (line_q),
      .hs_end   (lim.hs_end),
      .vs_end   (lim.vs_end),
      .de_start (lim.de_start),
      .de_end   (lim.de_end),
      .hsync_n  (hsync_n),
      .vsync_n  (vsync_n),
      .de       (de)
   );

   assign line_cnt = line_q;
   assign slot_cnt = slot_q;

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
   parameter int LINES_TOTAL = 244,
   parameter int TOP_BLANK   = 2,
   parameter int ACT_H       = 240,
   parameter int SLOT_W      = 10,
   parameter int LINE_W      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              hsync_n,
   input logic              vsync_n,
   input logic              de,
   input logic [LINE_W-1:0] line_cnt,
   input logic [SLOT_W-1:0] slot_cnt
);

   localparam int VIS_END = TOP_BLANK + ACT_H;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (hsync_n && vsync_n && !de && slot_cnt == '0 && line_cnt == '0)); // R1

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && slot_cnt != '0) |=>
         (slot_cnt == '0 || slot_cnt == SLOT_W'($past(slot_cnt) + 1'b1))); // R2

   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> (line_cnt == $past(line_cnt) || slot_cnt == '0)); // R3

   AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(line_cnt) < LINES_TOTAL); // R3

   AST_HS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!hsync_n && slot_cnt != '0) |-> !$past(hsync_n)); // R4

   AST_VS_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> (line_cnt == '0)); // R5

   AST_DE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (32'(line_cnt) >= TOP_BLANK && 32'(line_cnt) < VIS_END)); // R6

endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(
   .LINES_TOTAL (LINES_TOTAL),
   .TOP_BLANK   (TOP_BLANK),
   .ACT_H       (ACT_H),
   .SLOT_W      (SLOT_W),
   .LINE_W      (LINE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .hsync_n  (hsync_n),
   .vsync_n  (vsync_n),
   .de       (de),
   .line_cnt (line_cnt),
   .slot_cnt (slot_cnt)
);

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;

   localparam int CLK_PERIOD = 10;

   localparam int T_ACT_W  = 8;
   localparam int T_ACT_H  = 6;
   localparam int T_BLANK  = 4;
   localparam int T_LINE   = 12;
   localparam int T_HS     = 2;
   localparam int T_VS     = 2;
   localparam int T_START  = 2;
   localparam int T_C1     = 0;
   localparam int T_C2     = 3;
   localparam int T_C3     = 5;
   localparam int T_TOTAL  = T_ACT_H + T_BLANK;
   localparam int T_TOP    = T_BLANK / 2;
   localparam int T_SW     = $clog2(T_LINE * 3);
   localparam int T_LW     = $clog2(T_TOTAL);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic [1:0]       mode_sel = 2'b00;
   logic             hsync_n;
   logic             vsync_n;
   logic             de;
   logic [T_LW-1:0]  line_cnt;
   logic [T_SW-1:0]  slot_cnt;

   int nvec  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   // reference state
   bit erun = 1'b0;
   int eslot = 0;
   int eline = 0;
   int ecpp  = 1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lcd_sync_gen #(
      .ACT_W (T_ACT_W), .ACT_H (T_ACT_H), .BLANK_LINES (T_BLANK),
      .LINE_PIX (T_LINE), .HS_PIX (T_HS), .VS_PIX (T_VS),
      .START_PIX (T_START), .CORR_1 (T_C1), .CORR_2 (T_C2), .CORR_3 (T_C3)
   ) uut (
      .clk (clk), .rst_n (rst_n), .enable (enable), .mode_sel (mode_sel),
      .hsync_n (hsync_n), .vsync_n (vsync_n), .de (de),
      .line_cnt (line_cnt), .slot_cnt (slot_cnt)
   );

   function automatic int cpp_of(input logic [1:0] m);
      return (m == 2'b01) ? 2 : ((m == 2'b10) ? 3 : 1);
   endfunction

   function automatic int start_of(input int c);
      return T_START * c + ((c == 1) ? T_C1 : ((c == 2) ? T_C2 : T_C3));
   endfunction

   task automatic chk(input string tag, input string req, input string name,
                      input int got, input int exp);
      nvec++;
      if (got != exp) begin
         nfail++;
         $display("FAIL [%s] %s %s got %0d expected %0d", tag, req, name, got, exp);
      end
   endtask

   task automatic model_step();
      if (!rst_n) begin
         erun = 1'b0; eslot = 0; eline = 0; ecpp = 1;
      end else if (!enable) begin
         erun = 1'b0; eslot = 0; eline = 0;
      end else if (!erun) begin
         erun = 1'b1; eslot = 0; eline = 0; ecpp = cpp_of(mode_sel);
      end else if (eslot == T_LINE * ecpp - 1) begin
         eslot = 0;
         if (eline == T_TOTAL - 1) begin
            eline = 0;
            ecpp = cpp_of(mode_sel);
         end else begin
            eline++;
         end
      end else begin
         eslot++;
      end
   endtask

   task automatic compare(input string tag);
      int st = start_of(ecpp);
      int ehs = 1, evs = 1, ede = 0;
      if (erun) begin
         ehs = (eslot < T_HS * ecpp) ? 0 : 1;
         evs = (eline == 0 && eslot < T_VS * ecpp) ? 0 : 1;
         ede = (eline >= T_TOP && eline < T_TOP + T_ACT_H &&
                eslot >= st && eslot < st + T_ACT_W * ecpp) ? 1 : 0;
      end
      chk(tag, "R2", "slot_cnt", int'(slot_cnt), eslot);
      chk(tag, "R3", "line_cnt", int'(line_cnt), eline);
      chk(tag, "R4", "hsync_n", int'(hsync_n), ehs);
      chk(tag, "R5", "vsync_n", int'(vsync_n), evs);
      chk(tag, "R6", "de", int'(de), ede);
      if (erun && eline == T_TOP && eslot == st)
         chk(tag, "R8", "de at first valid slot", int'(de), 1);
      if (erun && eline == T_TOP && eslot == st - 1)
         chk(tag, "R8", "de before first valid slot", int'(de), 0);
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      model_step();
      compare(tag);
   endtask

   task automatic run_cycles(input int n, input string tag);
      for (int i = 0; i < n; i++) tick(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nfail++;
      $display("FAIL [watchdog] R1 run did not complete got 0 expected 1");
      finish_run();
   end

   initial begin
      // reset state (R1)
      run_cycles(3, "R1");
      chk("R1", "R1", "hsync_n in reset", int'(hsync_n), 1);
      chk("R1", "R1", "de in reset", int'(de), 0);
      rst_n = 1'b1;
      run_cycles(3, "R1");

      // sweep of every mode code, two full frames each (R7, R8)
      for (int m = 0; m < 4; m++) begin
         enable = 1'b0;
         run_cycles(2, "R1");
         mode_sel = 2'(m);
         enable = 1'b1;
         tick("R9");
         chk("R9", "R9", "slot at restart", int'(slot_cnt), 0);
         chk("R9", "R9", "line at restart", int'(line_cnt), 0);
         chk("R9", "R9", "hsync_n at restart", int'(hsync_n), 0);
         chk("R9", "R9", "vsync_n at restart", int'(vsync_n), 0);
         run_cycles(2 * T_LINE * cpp_of(2'(m)) * T_TOTAL + 3, "R7");
      end

      // mid-frame mode change: slow to fast, then fast to slow (R10)
      enable = 1'b0;
      run_cycles(1, "R1");
      mode_sel = 2'b10;
      enable = 1'b1;
      run_cycles(T_LINE * 3 * 3 + 7, "R10");
      mode_sel = 2'b00;
      run_cycles(T_LINE * 3 * T_TOTAL, "R10");
      chk("R10", "R10", "line period after wrap", int'(slot_cnt) < T_LINE ? 1 : 0, 1);
      mode_sel = 2'b01;
      run_cycles(T_LINE * 4 + 3, "R10");
      mode_sel = 2'b10;
      run_cycles(2 * T_LINE * 3 * T_TOTAL, "R10");

      // disable in mid-line, then restart (R9, R1)
      run_cycles(T_LINE * 2 + 5, "R9");
      enable = 1'b0;
      tick("R1");
      chk("R1", "R1", "slot after disable", int'(slot_cnt), 0);
      chk("R1", "R1", "vsync_n after disable", int'(vsync_n), 1);
      run_cycles(4, "R1");
      mode_sel = 2'b11;
      enable = 1'b1;
      tick("R9");
      chk("R9", "R9", "line after re-enable", int'(line_cnt), 0);
      run_cycles(T_LINE * T_TOTAL + 4, "R7");

      // reset in the middle of a frame (R1)
      rst_n = 1'b0;
      run_cycles(2, "R1");
      chk("R1", "R1", "line during reset", int'(line_cnt), 0);
      rst_n = 1'b1;
      run_cycles(T_LINE * T_TOTAL + 2, "R2");

      finish_run();
   end

endmodule